// File: doc/BRIEF.md
# Multi-Input Level Statistics Accumulator

This block measures signal levels on a group of parallel sample streams. Each lane carries signed 8-bit samples. A single valid strobe marks the cycles on which every lane holds a new sample.

After the host pulses a start request, the block adds up a fixed window of 2^16 accepted samples per lane. For each lane it keeps two totals: the plain sum of the samples and the sum of their squares. When the last sample of the window arrives, all totals are copied into a small result store in one step. The busy flag then drops and a done flag rises.

Software reads the store through an address/data port. From the two totals it can derive the mean and the RMS level of every input. The stored results stay unchanged until the next measurement completes, so a read never sees a half-updated set.

Top module: `level_stats_acc`

## Requirements
- R1: After a synchronous active-low reset, busy and done are low and every result word reads as zero.
- R2: A start request while not busy makes busy high and done low on the next clock edge. The totals and the sample count of the new window begin from zero.
- R3: A lane sample counts only on a cycle where busy and the valid strobe are both high. A valid strobe while not busy changes neither the results nor the flags.
- R4: The sum of the samples for input i is a 24-bit two's complement total. It is read at address 2i, sign-extended to 32 bits.
- R5: The sum of squared samples for input i is a 32-bit unsigned total read at address 2i+1. Samples are two's complement, so -128 squares to 16384.
- R6: On the clock edge that accepts the 2^16-th sample of a window (2^WIN_LOG2 in general), busy falls and done rises. On that same edge, every result word is replaced by totals that include that final sample.
- R7: A start request while busy is ignored. The window continues with its count and totals untouched.
- R8: Result words change only on the completing edge of a window. Reads during a measurement return the previous window's values.
- R9: A read has one cycle of latency. The data output presents the word at the address sampled on the preceding clock edge.
- R10: Busy and done are never high together. Done stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Start request, one cycle |
| smp_valid_i | input | 1 | All lanes carry a sample this cycle |
| smp_data_i | input | N_IN*SMP_W (64) | Lane i in bits [8i+7:8i], two's complement |
| rd_addr_i | input | $clog2(2*N_IN) (4) | Result word address: 2i sum, 2i+1 sum of squares |
| busy_o | output | 1 | Measurement in progress |
| done_o | output | 1 | Results of a completed window are held |
| rd_data_o | output | 32 | Registered read data |

## Verification
On every cycle, the embedded assertions check several relations:
- The sample counter holds still when no sample is accepted, and steps by exactly one when a start request collides with a sample mid-window.
- Accumulators move only when enabled or cleared.
- The result store is frozen except on a completing edge.
- A completing edge always leaves done high with busy low, and an accepted start always yields busy without done.

The arithmetic can be shown only by the bench's scenarios. These are the exact totals for extreme and mixed sample patterns, the sign extension of negative sums, the interleaved address map, the effect of idle gaps and of a start that arrives mid-window, and the one-cycle read latency. A full-length 2^16 window at the smallest sample value exercises the edges of both result widths.

// File: rtl/level_stats_pkg.sv
// Package: shared constants and state encoding for the level statistics block.
// Assumes: result words are 32 bits wide on the read port.
package level_stats_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } meas_state_e;

endpackage

// File: rtl/level_stats_ctrl.sv
// Module: window controller. Accepts a start when not running, counts accepted
// samples and flags the final sample of a 2^WIN_LOG2 window.
// Assumes: start_i is a single-cycle request; samples arrive with smp_valid_i.
module level_stats_ctrl
    import level_stats_pkg::*;
#(
    parameter int WIN_LOG2 = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic smp_valid_i,
    output logic clear_o,
    output logic acc_en_o,
    output logic commit_o,
    output logic busy_o,
    output logic done_o
);

    meas_state_e         state_q;
    logic [WIN_LOG2-1:0] cnt_q;

    // Decode the per-cycle controls from the state and inputs.
    always_comb begin
        clear_o  = start_i && (state_q != ST_RUN);
        acc_en_o = (state_q == ST_RUN) && smp_valid_i;
        commit_o = acc_en_o && (cnt_q == {WIN_LOG2{1'b1}});
        busy_o   = (state_q == ST_RUN);
        done_o   = (state_q == ST_HOLD);
    end

    // Advance the measurement state and the sample count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (clear_o) begin
            state_q <= ST_RUN;
            cnt_q   <= '0;
        end else if (acc_en_o) begin
            cnt_q <= cnt_q + 1'b1;
            if (commit_o) state_q <= ST_HOLD;
        end
    end

    // R3
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en_o && !clear_o) |=> $stable(cnt_q));

    // R7
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && smp_valid_i && !commit_o) |=> (busy_o && cnt_q == $past(cnt_q) + 1'b1));

    // R6
    window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit_o |=> (done_o && !busy_o));

endmodule

// File: rtl/level_stats_lane.sv
// Module: one input lane. Keeps the running sum and sum of squares of its
// samples and exposes the totals including the current sample.
// Assumes: clear_i and acc_en_i are never high together.
module level_stats_lane #(
    parameter int SMP_W = 8,
    parameter int SUM_W = 24,
    parameter int SQ_W  = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             acc_en_i,
    input  logic [SMP_W-1:0] smp_i,
    output logic [SUM_W-1:0] sum_nxt_o,
    output logic [SQ_W-1:0]  sq_nxt_o
);

    localparam int PROD_W = 2 * SMP_W;

    logic [SUM_W-1:0]         sum_q;
    logic [SQ_W-1:0]          sq_q;
    logic signed [SMP_W-1:0]  smp_s;
    logic signed [PROD_W-1:0] prod;

    // Form the totals that include this cycle's sample.
    always_comb begin
        smp_s     = $signed(smp_i);
        prod      = smp_s * smp_s;
        sum_nxt_o = sum_q + {{(SUM_W-SMP_W){smp_i[SMP_W-1]}}, smp_i};
        sq_nxt_o  = sq_q + {{(SQ_W-PROD_W){1'b0}}, prod};
    end

    // Hold, clear or advance the running totals.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            sum_q <= '0;
            sq_q  <= '0;
        end else if (acc_en_i) begin
            sum_q <= sum_nxt_o;
            sq_q  <= sq_nxt_o;
        end
    end

    // R3
    lane_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_en_i && !clear_i) |=> ($stable(sum_q) && $stable(sq_q)));

endmodule

// File: rtl/level_stats_store.sv
// Module: result store. Captures every lane's totals in one step on commit,
// laid out as sum at word 2i and sum of squares at word 2i+1, with a
// registered read port.
// Assumes: the sum total is two's complement and is sign-extended on capture.
module level_stats_store
    import level_stats_pkg::*;
#(
    parameter int N_IN   = 8,
    parameter int SUM_W  = 24,
    parameter int SQ_W   = 32,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   commit_i,
    input  logic [N_IN*SUM_W-1:0]  sum_i,
    input  logic [N_IN*SQ_W-1:0]   sq_i,
    input  logic [ADDR_W-1:0]      rd_addr_i,
    output logic [WORD_W-1:0]      rd_data_o
);

    localparam int N_WORDS = 2 * N_IN;

    logic [N_WORDS*WORD_W-1:0] store_q;

    // Capture all result words together at the end of a window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store_q <= '0;
        end else if (commit_i) begin
            for (int i = 0; i < N_IN; i++) begin
                store_q[(2*i)*WORD_W +: WORD_W] <=
                    {{(WORD_W-SUM_W){sum_i[i*SUM_W+SUM_W-1]}}, sum_i[i*SUM_W +: SUM_W]};
                store_q[(2*i+1)*WORD_W +: WORD_W] <=
                    {{(WORD_W-SQ_W){1'b0}}, sq_i[i*SQ_W +: SQ_W]};
            end
        end
    end

    // Present the addressed word one cycle after the address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (32'(rd_addr_i) < N_WORDS) begin
            rd_data_o <= store_q[32'(rd_addr_i)*WORD_W +: WORD_W];
        end else begin
            rd_data_o <= '0;
        end
    end

    // R8
    store_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(store_q));

endmodule

// File: rtl/level_stats_acc.sv
// Module: top of the level statistics accumulator. One lane per input, a
// shared window controller, and the result store with its read port.
// Assumes: lane i occupies bits [SMP_W*i +: SMP_W] of smp_data_i.
module level_stats_acc
    import level_stats_pkg::*;
#(
    parameter int N_IN     = 8,
    parameter int SMP_W    = 8,
    parameter int WIN_LOG2 = 16,
    parameter int SUM_W    = 24,
    parameter int SQ_W     = 32,
    localparam int ADDR_W  = $clog2(2 * N_IN)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic                    smp_valid_i,
    input  logic [N_IN*SMP_W-1:0]   smp_data_i,
    input  logic [ADDR_W-1:0]       rd_addr_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic [WORD_W-1:0]       rd_data_o
);

    logic                  clear;
    logic                  acc_en;
    logic                  commit;
    logic [N_IN*SUM_W-1:0] sum_all;
    logic [N_IN*SQ_W-1:0]  sq_all;

    level_stats_ctrl #(
        .WIN_LOG2 (WIN_LOG2)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .smp_valid_i (smp_valid_i),
        .clear_o     (clear),
        .acc_en_o    (acc_en),
        .commit_o    (commit),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    for (genvar g = 0; g < N_IN; g++) begin : g_lane
        level_stats_lane #(
            .SMP_W (SMP_W),
            .SUM_W (SUM_W),
            .SQ_W  (SQ_W)
        ) u_lane (
            .clk       (clk),
            .rst_n     (rst_n),
            .clear_i   (clear),
            .acc_en_i  (acc_en),
            .smp_i     (smp_data_i[g*SMP_W +: SMP_W]),
            .sum_nxt_o (sum_all[g*SUM_W +: SUM_W]),
            .sq_nxt_o  (sq_all[g*SQ_W +: SQ_W])
        );
    end

    level_stats_store #(
        .N_IN   (N_IN),
        .SUM_W  (SUM_W),
        .SQ_W   (SQ_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit_i  (commit),
        .sum_i     (sum_all),
        .sq_i      (sq_all),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o)
    );

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

endmodule

// File: tb/level_stats_acc_bench.sv
module level_stats_acc_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N_IN   = 8;
    localparam int SWIN   = 4;
    localparam int SLEN   = 1 << SWIN;
    localparam int NWORDS = 2 * N_IN;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;

    logic        s_start = 1'b0, s_valid = 1'b0;
    logic [63:0] s_data = '0;
    logic [3:0]  s_addr = '0;
    logic        s_busy, s_done;
    logic [31:0] s_rdata;

    logic        f_start = 1'b0, f_valid = 1'b0;
    logic [63:0] f_data = '0;
    logic [3:0]  f_addr = '0;
    logic        f_busy, f_done;
    logic [31:0] f_rdata;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_w [NWORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    level_stats_acc u_level_stats_acc (
        .clk(clk), .rst_n(rst_n), .start_i(f_start), .smp_valid_i(f_valid),
        .smp_data_i(f_data), .rd_addr_i(f_addr), .busy_o(f_busy),
        .done_o(f_done), .rd_data_o(f_rdata)
    );

    level_stats_acc #(.WIN_LOG2(SWIN)) u_level_stats_acc_small (
        .clk(clk), .rst_n(rst_n), .start_i(s_start), .smp_valid_i(s_valid),
        .smp_data_i(s_data), .rd_addr_i(s_addr), .busy_o(s_busy),
        .done_o(s_done), .rd_data_o(s_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int smp(input int pat, input int lane, input int k);
        case (pat)
            0: return -128;
            1: return 127;
            2: return ((k * 37 + lane * 29 + 3) % 256) - 128;
            default: return (lane % 2 == 1) ? (k - 8) : -(k * 7 + lane);
        endcase
    endfunction

    // Read one word of the small instance, checking the registered latency.
    task automatic rd_small(input int a, output logic [31:0] d);
        s_addr = 4'(a);
        @(negedge clk);
        d = s_rdata;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        for (int a = 0; a < NWORDS; a++) begin
            rd_small(a, d);
            chk($sformatf("%s word%0d", req, a), d, exp_w[a]);
        end
    endtask

    // One window on the small instance; optional idle gaps and a mid-window start.
    task automatic run_small(input int pat, input bit gaps, input bit mid_start);
        longint sum [N_IN];
        longint sq [N_IN];
        logic [31:0] d;
        for (int i = 0; i < N_IN; i++) begin sum[i] = 0; sq[i] = 0; end
        @(negedge clk);
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk("R2 busy after start", {31'b0, s_busy}, 32'd1);
        chk("R2 done cleared", {31'b0, s_done}, 32'd0);
        rd_small(0, d);
        chk("R8 old result during window", d, exp_w[0]);
        for (int k = 0; k < SLEN; k++) begin
            for (int i = 0; i < N_IN; i++) begin
                s_data[i*8 +: 8] = 8'(smp(pat, i, k));
                sum[i] += smp(pat, i, k);
                sq[i]  += smp(pat, i, k) * smp(pat, i, k);
            end
            s_valid = 1'b1;
            s_start = (mid_start && k == 5);
            @(negedge clk);
            s_valid = 1'b0;
            s_start = 1'b0;
            if (gaps && (k % 3 == 1)) begin
                s_data = '1;
                @(negedge clk);
                @(negedge clk);
            end
            if (k == SLEN - 2)
                chk("R6 busy before final sample", {31'b0, s_busy}, 32'd1);
        end
        chk("R6 done after window", {31'b0, s_done}, 32'd1);
        chk("R6 busy low after window", {31'b0, s_busy}, 32'd0);
        for (int i = 0; i < N_IN; i++) begin
            exp_w[2*i]   = 32'(sum[i]);
            exp_w[2*i+1] = 32'(sq[i]);
        end
        check_all(mid_start ? "R7 R4 R5 results" : "R4 R5 results");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 busy", {31'b0, s_busy}, 32'd0);
        chk("R1 done", {31'b0, s_done}, 32'd0);
        chk("R1 full busy", {31'b0, f_busy}, 32'd0);
        for (int a = 0; a < NWORDS; a++) exp_w[a] = '0;
        check_all("R1 reset word");

        run_small(0, 1'b0, 1'b0);
        run_small(1, 1'b1, 1'b0);
        run_small(2, 1'b1, 1'b1);
        run_small(3, 1'b0, 1'b0);

        // R3: valid while idle has no effect
        s_data = '1;
        s_valid = 1'b1;
        repeat (4) @(negedge clk);
        s_valid = 1'b0;
        chk("R3 done held", {31'b0, s_done}, 32'd1);
        chk("R3 busy held", {31'b0, s_busy}, 32'd0);
        check_all("R3 ignored valid");

        // R9: one cycle read latency
        s_addr = 4'd2;
        @(negedge clk);
        s_addr = 4'd3;
        #1;
        chk("R9 old word before edge", s_rdata, exp_w[2]);
        @(negedge clk);
        chk("R9 new word after edge", s_rdata, exp_w[3]);

        // R10 and R2 on restart from done
        @(negedge clk);
        s_start = 1'b1;
        @(negedge clk);
        s_start = 1'b0;
        chk("R10 done cleared on restart", {s_busy, s_done}, 2'b10);

        // Full 2^16 window on the default instance at the smallest sample value
        @(negedge clk);
        f_start = 1'b1;
        @(negedge clk);
        f_start = 1'b0;
        f_data = {8{8'h80}};
        f_valid = 1'b1;
        repeat ((1 << 16) - 1) @(negedge clk);
        chk("R6 full busy before last", {31'b0, f_busy}, 32'd1);
        @(negedge clk);
        f_valid = 1'b0;
        chk("R6 full done", {f_busy, f_done}, 2'b01);
        f_addr = 4'd14;
        @(negedge clk);
        chk("R4 full sum sign-extended", f_rdata, 32'hFF80_0000);
        f_addr = 4'd15;
        @(negedge clk);
        chk("R5 full square sum", f_rdata, 32'h4000_0000);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule